// File: doc/BRIEF.md
# Tone-Burst Command Transmitter

This block sends a short command message to a satellite outdoor unit by keying a 22 kHz square wave on and off on a single control line. The host first loads the message bytes into a small buffer and sets the message length through a plain register write port. It then writes a 3-bit mode value. Mode 0 holds the line quiet. Mode 1 drives a continuous carrier. Writing mode 4 sends the stored message once.

Each byte goes out most significant bit first and is followed by an odd-parity bit. Every bit takes three equal time units of 0.5 ms. A zero is two units of carrier and then one unit of silence. A one is one unit of carrier and then two units of silence. When the last bit ends, the line falls quiet and `busy` drops. After a further fixed quiet interval, `listen` rises to tell a companion receiver that a reply may arrive. The buffer keeps its contents, so the host can send the same message again by writing mode 4 once more. Afterwards the host writes mode 0 or 1 to bring back the earlier carrier state.

The carrier comes from dividing the system clock: `HALF_CLKS` clock cycles per half period. The default suits a 100 MHz clock, where 2273 gives 21.997 kHz. One time unit is `TONES_PER_UNIT` carrier periods, which is 11 at 22 kHz. The listen delay is `LISTEN_UNITS` units, which is 10 for 5 ms. `DEPTH` is a power of two.

Top module: `diseqc_tx`

## Requirements
- R1: After reset the mode is 0. Whenever the block is not sending and the mode is any value other than 1, `lnb_tone` is 0.
- R2: While the mode is 1 and the block is not sending, `lnb_tone` is a square wave that spends HALF_CLKS cycles high and HALF_CLKS cycles low.
- R3: A write of mode 4 while idle, with a nonzero stored length, starts a message. `busy` is 1 from the next cycle for exactly length × 27 × U cycles, where U = 2 × HALF_CLKS × TONES_PER_UNIT.
- R4: Each bit is three units of U cycles. Unit 0 carries the tone. Unit 1 carries the tone only for a 0 bit. Unit 2 is silent. The tone is gated by the carrier, which restarts in its high half on the first cycle of the message.
- R5: Bytes are sent from buffer address 0 upward, bit 7 first. After bit 0 of each byte comes a ninth bit that makes the count of ones in the nine bits odd.
- R6: While `busy` is 1, writes to the buffer and to the length are ignored.
- R7: While `busy` is 1, mode writes are ignored.
- R8: The buffer and the length keep their values after a message. A second mode-4 write sends the same message again.
- R9: `listen` is 0 after reset. It rises LISTEN_UNITS × U cycles after the end of a message, stays 1 until the next message starts, and is never 1 while `busy` is 1.
- R10: A mode-4 write with a stored length of 0 starts nothing. A length written above DEPTH is stored as DEPTH.
- R11: Immediately after reset, `busy`, `listen` and `lnb_tone` are all 0.
- R12: After a message, while the mode stays 4, the line remains quiet. A later write of mode 1 brings back the continuous carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode value: 0 quiet, 1 carrier, 4 send |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_addr | input | $clog2(DEPTH) | Buffer byte address |
| buf_wdata | input | 8 | Buffer byte data |
| len_we | input | 1 | Length write strobe |
| len_wdata | input | $clog2(DEPTH+1) | Message length in bytes |
| lnb_tone | output | 1 | Keyed 22 kHz control line |
| busy | output | 1 | High while a message is being sent |
| listen | output | 1 | Reply window open |

## Verification
The assertions assume that every write strobe lasts one clock cycle and that its data is valid in that same cycle. They also assume that the host only writes the length and the buffer when it means to, because the lock checks hold only for the cycles in which `busy` is already high. The stimulus drives each strobe for exactly one cycle, half a cycle away from the active edge. It draws the message bytes and lengths from a seeded generator, and it places the ignored writes deliberately in the middle of a message.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_QUIET   = 3'd0;
    localparam mode_t MODE_CARRIER = 3'd1;
    localparam mode_t MODE_SEND    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    // three time units inside one bit cell
    typedef enum logic [1:0] {
        PH_MARK  = 2'd0,
        PH_SHAPE = 2'd1,
        PH_SPACE = 2'd2
    } phase_e;

    typedef struct packed {
        logic sq;    // carrier level
        logic tick;  // last cycle of a time unit
    } tone_t;

    localparam int BITS_PER_CELL = 9;

    // ninth bit: total ones across data and parity is odd
    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/dtx_tone_gen.sv
module dtx_tone_gen
    import dtx_pkg::*;
#(
    parameter int HALF_CLKS      = 2273,
    parameter int TONES_PER_UNIT = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    output tone_t tone
);
    localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int PW = (TONES_PER_UNIT > 1) ? $clog2(TONES_PER_UNIT) : 1;

    logic [HW-1:0] half_cnt;
    logic [PW-1:0] per_cnt;
    logic          sq_q;
    logic          half_end;

    assign half_end = (half_cnt == HW'(HALF_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            half_cnt <= '0;
            per_cnt  <= '0;
            sq_q     <= 1'b1;
        end else if (half_end) begin
            half_cnt <= '0;
            sq_q     <= ~sq_q;
            if (!sq_q) begin
                per_cnt <= (per_cnt == PW'(TONES_PER_UNIT - 1)) ? '0 : per_cnt + 1'b1;
            end
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    assign tone.sq   = sq_q;
    assign tone.tick = half_end && !sq_q && (per_cnt == PW'(TONES_PER_UNIT - 1));

endmodule

// File: rtl/dtx_msg_buffer.sv
module dtx_msg_buffer #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    input  logic          len_we,
    input  logic [LW-1:0] len_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic [LW-1:0] len_q
);
    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (buf_we && !lock && (buf_addr == AW'(i))) begin
                cells[i] <= buf_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (len_we && !lock) begin
            len_q <= (len_wdata > LW'(DEPTH)) ? LW'(DEPTH) : len_wdata;
        end
    end

    assign rd_byte = cells[rd_addr];

endmodule

// File: rtl/dtx_sequencer.sv
module dtx_sequencer
    import dtx_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int LISTEN_UNITS = 10,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1),
    localparam int GW = (LISTEN_UNITS > 1) ? $clog2(LISTEN_UNITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tick,
    input  logic [LW-1:0] len,
    input  logic [7:0]    cur_byte,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          listen,
    output logic          mark
);
    tx_state_e     st;
    phase_e        ph;
    logic [LW-1:0] byte_idx;
    logic [3:0]    bit_idx;
    logic [GW-1:0] gap_cnt;
    logic          listen_q;
    logic          cur_bit;
    logic          last_bit;

    assign last_bit = (bit_idx == 4'(BITS_PER_CELL - 1));
    assign cur_bit  = last_bit ? odd_parity(cur_byte) : cur_byte[3'd7 - bit_idx[2:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= PH_MARK;
            byte_idx <= '0;
            bit_idx  <= '0;
            gap_cnt  <= '0;
            listen_q <= 1'b0;
        end else if (start) begin
            st       <= ST_SEND;
            ph       <= PH_MARK;
            byte_idx <= '0;
            bit_idx  <= '0;
            listen_q <= 1'b0;
        end else if (tick) begin
            case (st)
                ST_SEND: begin
                    if (ph == PH_SPACE) begin
                        ph <= PH_MARK;
                        if (last_bit) begin
                            bit_idx <= '0;
                            if (byte_idx == len - 1'b1) begin
                                st      <= ST_GAP;
                                gap_cnt <= '0;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        ph <= (ph == PH_MARK) ? PH_SHAPE : PH_SPACE;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(LISTEN_UNITS - 1)) begin
                        st       <= ST_IDLE;
                        listen_q <= 1'b1;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_addr = byte_idx[AW-1:0];
    assign busy    = (st == ST_SEND);
    assign listen  = listen_q;
    assign mark    = (st == ST_SEND) && ((ph == PH_MARK) || ((ph == PH_SHAPE) && !cur_bit));

endmodule

// File: rtl/diseqc_tx.sv
module diseqc_tx
    import dtx_pkg::*;
#(
    parameter int HALF_CLKS      = 2273,
    parameter int TONES_PER_UNIT = 11,
    parameter int LISTEN_UNITS   = 10,
    parameter int DEPTH          = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_we,
    input  logic [2:0]    mode_wdata,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    input  logic          len_we,
    input  logic [LW-1:0] len_wdata,
    output logic          lnb_tone,
    output logic          busy,
    output logic          listen
);
    mode_t         mode_q;
    tone_t         tone;
    logic          start;
    logic          mark;
    logic [7:0]    cur_byte;
    logic [AW-1:0] rd_addr;
    logic [LW-1:0] len_q;

    assign start = mode_we && !busy && (mode_wdata == MODE_SEND) && (len_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_QUIET;
        end else if (mode_we && !busy) begin
            mode_q <= mode_wdata;
        end
    end

    dtx_tone_gen #(
        .HALF_CLKS     (HALF_CLKS),
        .TONES_PER_UNIT(TONES_PER_UNIT)
    ) u_tone (
        .clk    (clk),
        .rst    (rst),
        .restart(start),
        .tone   (tone)
    );

    dtx_msg_buffer #(
        .DEPTH(DEPTH)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .lock     (busy),
        .buf_we   (buf_we),
        .buf_addr (buf_addr),
        .buf_wdata(buf_wdata),
        .len_we   (len_we),
        .len_wdata(len_wdata),
        .rd_addr  (rd_addr),
        .rd_byte  (cur_byte),
        .len_q    (len_q)
    );

    dtx_sequencer #(
        .DEPTH       (DEPTH),
        .LISTEN_UNITS(LISTEN_UNITS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tone.tick),
        .len     (len_q),
        .cur_byte(cur_byte),
        .rd_addr (rd_addr),
        .busy    (busy),
        .listen  (listen),
        .mark    (mark)
    );

    assign lnb_tone = tone.sq && (busy ? mark : (mode_q == MODE_CARRIER));

endmodule

// File: rtl/dtx_checker.sv
module dtx_checker #(
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_we,
    input logic [2:0]    mode_wdata,
    input logic          busy,
    input logic          listen,
    input logic          lnb_tone,
    input logic [2:0]    mode_q,
    input logic [LW-1:0] len_q
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mode_we && !busy && mode_wdata == 3'd4 && len_q != '0) |=> busy); // R3

    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_we && !busy && mode_wdata == 3'd4 && len_q == '0) |=> !busy); // R10

    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(len_q)); // R6

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q)); // R7

    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode_q != 3'd1) |-> !lnb_tone); // R1

    AST_LISTEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        listen |-> !busy); // R9

    AST_LISTEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !listen); // R9
endmodule

bind diseqc_tx dtx_checker #(.LW(LW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (mode_we),
    .mode_wdata(mode_wdata),
    .busy      (busy),
    .listen    (listen),
    .lnb_tone  (lnb_tone),
    .mode_q    (mode_q),
    .len_q     (len_q)
);

// File: tb/diseqc_tx_test.sv
module diseqc_tx_test;
    localparam int H = 2;
    localparam int T = 2;
    localparam int L = 3;
    localparam int D = 8;
    localparam int U = 2 * H * T;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic       buf_we = 1'b0;
    logic [2:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic       len_we = 1'b0;
    logic [3:0] len_wdata = '0;
    logic       lnb_tone, busy, listen;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] msg [D];
    int         msg_len = 0;

    always #5 clk = ~clk;

    diseqc_tx #(
        .HALF_CLKS(H), .TONES_PER_UNIT(T), .LISTEN_UNITS(L), .DEPTH(D)
    ) uut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .len_we(len_we), .len_wdata(len_wdata),
        .lnb_tone(lnb_tone), .busy(busy), .listen(listen)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int exp_tone(input int k);
        int   u    = k / U;
        int   b    = u / 3;
        int   ph   = u % 3;
        int   bp   = b % 9;
        logic [7:0] by = msg[b / 9];
        logic bitv = (bp == 8) ? ~(^by) : by[7 - bp];
        logic mk   = (ph == 0) || (ph == 1 && !bitv);
        return (mk && ((k % (2 * H)) < H)) ? 1 : 0;
    endfunction

    task automatic write_mode(input logic [2:0] v);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic load(input int n);
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_addr = 3'(i); buf_wdata = msg[i];
        end
        @(negedge clk);
        buf_we = 1'b0;
        len_we = 1'b1; len_wdata = 4'(n);
        @(negedge clk);
        len_we = 1'b0;
        msg_len = (n > D) ? D : n;
    endtask

    // mode-4 write, then per-cycle compare of line, busy and listen (R3 R4 R5 R9)
    task automatic send_and_check(input bit poke);
        int n_end = msg_len * 27 * U;
        write_mode(3'd4);
        for (int k = 0; k <= n_end + L * U + 3; k++) begin
            chk("R4/R5 line", int'(lnb_tone), exp_tone(k) * ((k < n_end) ? 1 : 0));
            chk("R3 busy", int'(busy), (k < n_end) ? 1 : 0);
            chk("R9 listen", int'(listen), (k >= n_end + L * U) ? 1 : 0);
            if (poke && k == 5) begin
                // R6 R7: writes during a message must change nothing
                buf_we = 1'b1; buf_addr = 3'd0; buf_wdata = ~msg[0];
                len_we = 1'b1; len_wdata = 4'd1;
                mode_we = 1'b1; mode_wdata = 3'd1;
            end else begin
                buf_we = 1'b0; len_we = 1'b0; mode_we = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic carrier_check(input string req);
        int hi = 0;
        for (int i = 0; i < 8 * H; i++) begin
            if (lnb_tone) hi++;
            @(negedge clk);
        end
        chk(req, hi, 4 * H);
    endtask

    task automatic quiet_check(input string req, input int cycles);
        int hi = 0;
        for (int i = 0; i < cycles; i++) begin
            if (lnb_tone) hi++;
            @(negedge clk);
        end
        chk(req, hi, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7131));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 listen", int'(listen), 0);
        chk("R11 line", int'(lnb_tone), 0);
        quiet_check("R1 reset mode quiet", 20);

        // R2 continuous carrier
        write_mode(3'd1);
        carrier_check("R2 carrier duty");
        chk("R2 busy", int'(busy), 0);
        // R1 back to quiet
        write_mode(3'd0);
        quiet_check("R1 mode 0 quiet", 20);

        // directed message with writes poked mid-send
        msg[0] = 8'hE0; msg[1] = 8'h10; msg[2] = 8'h38;
        for (int i = 3; i < D; i++) msg[i] = 8'h00;
        load(3);
        send_and_check(1'b1);
        // R12: mode stays 4, line quiet
        quiet_check("R12 quiet after send", 20);
        // R8 repeat with no reload
        send_and_check(1'b0);
        // R12 carrier restored
        write_mode(3'd1);
        carrier_check("R12 carrier restored");
        write_mode(3'd0);

        // parity corners
        msg[0] = 8'h00; msg[1] = 8'hFF;
        load(2);
        send_and_check(1'b0);

        // R10 zero length starts nothing, listen remains set
        load(0);
        write_mode(3'd4);
        for (int i = 0; i < 30; i++) begin
            chk("R10 zero length busy", int'(busy), 0);
            chk("R10 zero length line", int'(lnb_tone), 0);
            chk("R10 listen kept", int'(listen), 1);
            @(negedge clk);
        end

        // R10 oversize length held as DEPTH
        for (int i = 0; i < D; i++) msg[i] = 8'($urandom);
        load(12);
        chk("R10 clamp", msg_len, D);
        send_and_check(1'b0);

        // random messages
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < D; i++) msg[i] = 8'($urandom);
            load(1 + int'($urandom % D));
            send_and_check(t == 2);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule